// File: doc/BRIEF.md
# Decode Accelerator Control and Interrupt Register

This block is the single 32-bit control and status word of a picture-decoding accelerator. Software reaches it over a simple memory-mapped register bus. A strobed write with a matching address updates the word. A strobed read returns the word one cycle later on a registered data output.

Software starts a decode by writing 1 to the run bit. The decoding core then reports how the decode ended with one-cycle pulses: picture finished, stream fault, stream abort, memory bus fault, or watchdog expiry. Any of these pulses ends the run. It also latches the matching status flag and raises the decoder's interrupt flag. Starting a new decode wipes the old status.

The interrupt line is registered. It is the OR of the decoder's flag and a flag from a separate post-processing unit. A mask bit silences only the decoder's share of that line.

Top module: `acc_ctl_reg`

## Requirements
- R1: A synchronous active-high reset clears every bit of the word to 0, and also drives the read data and the interrupt output to 0.
- R2: The field positions are: run bit 0, decoder interrupt mask bit 4, decoder interrupt flag bit 8, picture-done bit 12, bus-fault bit 13, stream-fault bit 14, stream-abort bit 15, pending bit 16, timeout bit 18. Software can write only bits 0, 4 and 8. All other bits read 0.
- R3: A write with bit 0 set (start) sets the run bit and clears bits 12, 13, 14, 15 and 18.
- R4: A picture-done pulse clears the run bit and sets bit 12 and bit 8.
- R5: A stream-fault, stream-abort, bus-fault or timeout pulse clears the run bit and sets its own status bit (14, 15, 13 or 18) together with bit 8.
- R6: A write with bit 0 clear leaves bits 12 to 18 unchanged, whatever data it carries in those positions.
- R7: The interrupt output is registered. One cycle after bit 8 changes, it follows (bit 8 AND NOT bit 4) OR the post-processor flag.
- R8: While bit 4 is 1, the decoder cannot raise the interrupt output, but the post-processor flag still drives it.
- R9: A write with bit 8 clear clears the decoder interrupt flag.
- R10: When a completion or error pulse arrives in the same cycle as a write, the pulse takes priority for the run bit, the flag and the status bits.
- R11: Bit 16 reads as bit 8 AND NOT bit 4.
- R12: Writes to any other address have no effect. Reads from any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| ev_done | input | 1 | Picture finished pulse |
| ev_strm_err | input | 1 | Stream fault pulse |
| ev_abort | input | 1 | Stream abort pulse |
| ev_bus_err | input | 1 | Memory bus fault pulse |
| ev_timeout | input | 1 | Watchdog expiry pulse |
| pp_irq | input | 1 | Post-processor interrupt flag |
| irq_o | output | 1 | Registered merged interrupt |

## Verification
The assertions assume that the event inputs are single-cycle pulses sampled on the clock edge. They also assume that bus strobes come with a stable address and data. The properties for writes only apply in cycles with no event pulse, and the collision case is covered by its own bench check. The bench changes every input on the falling clock edge and holds each pulse for one cycle. It fires one event at a time, except in the deliberate write-versus-event collision.

// File: rtl/acc_ctl_pkg.sv
package acc_ctl_pkg;
  localparam int REG_W   = 32;
  localparam int B_RUN   = 0;
  localparam int B_MASK  = 4;
  localparam int B_FLAG  = 8;
  localparam int B_DONE  = 12;
  localparam int B_BUSF  = 13;
  localparam int B_STRM  = 14;
  localparam int B_ABRT  = 15;
  localparam int B_PEND  = 16;
  localparam int B_TMO   = 18;

  typedef struct packed {
    logic tmo;
    logic abrt;
    logic strm;
    logic busf;
    logic done;
  } stat_t;

  function automatic logic [REG_W-1:0] build_image(
    input logic run, input logic mask, input logic flag, input stat_t st);
    logic [REG_W-1:0] w;
    w         = '0;
    w[B_RUN]  = run;
    w[B_MASK] = mask;
    w[B_FLAG] = flag;
    w[B_DONE] = st.done;
    w[B_BUSF] = st.busf;
    w[B_STRM] = st.strm;
    w[B_ABRT] = st.abrt;
    w[B_PEND] = flag & ~mask;
    w[B_TMO]  = st.tmo;
    return w;
  endfunction
endpackage

// File: rtl/acc_ctl_bus.sv
module acc_ctl_bus
  import acc_ctl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  image,
  output logic              wr_hit,
  output logic [REG_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

  logic sel;
  assign sel    = (bus_addr == MATCH);
  assign wr_hit = bus_wr & sel;

  always_ff @(posedge clk) begin
    if (rst)                rdata <= '0;
    else if (bus_rd && sel) rdata <= image;
    else                    rdata <= '0;
  end
endmodule

// File: rtl/acc_ctl_flags.sv
module acc_ctl_flags
  import acc_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_hit,
  input  logic  wd_run,
  input  logic  wd_mask,
  input  logic  wd_flag,
  input  stat_t ev,
  output logic  run_q,
  output logic  mask_q,
  output logic  flag_q,
  output stat_t stat_q
);
  logic  term;
  logic  start;
  stat_t stat_n;

  assign term  = |ev;
  assign start = wr_hit & wd_run;

  // each status bit: event sets, a new start clears, otherwise hold
  always_comb begin
    if (start) stat_n = '0;
    else       stat_n = stat_q;
    stat_n = stat_n | ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      mask_q <= 1'b0;
      flag_q <= 1'b0;
      stat_q <= '0;
    end else begin
      stat_q <= stat_n;
      if (wr_hit) mask_q <= wd_mask;
      if (term)        run_q <= 1'b0;
      else if (wr_hit) run_q <= wd_run;
      if (term)        flag_q <= 1'b1;
      else if (wr_hit) flag_q <= wd_flag;
    end
  end
endmodule

// File: rtl/acc_ctl_irq.sv
module acc_ctl_irq (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  input  logic mask,
  input  logic pp_irq,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (flag & ~mask) | pp_irq;
  end
endmodule

// File: rtl/acc_ctl_reg.sv
module acc_ctl_reg
  import acc_ctl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_done,
  input  logic              ev_strm_err,
  input  logic              ev_abort,
  input  logic              ev_bus_err,
  input  logic              ev_timeout,
  input  logic              pp_irq,
  output logic              irq_o
);
  logic             wr_hit;
  logic             run_q;
  logic             mask_q;
  logic             flag_q;
  stat_t            stat_q;
  stat_t            ev;
  logic [REG_W-1:0] image;
  logic             unused_wdata;

  assign ev = '{tmo: ev_timeout, abrt: ev_abort, strm: ev_strm_err,
                busf: ev_bus_err, done: ev_done};
  assign image        = build_image(run_q, mask_q, flag_q, stat_q);
  assign unused_wdata = ^bus_wdata;

  acc_ctl_bus #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_bus (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .image(image), .wr_hit(wr_hit), .rdata(bus_rdata)
  );

  acc_ctl_flags u_flags (
    .clk(clk), .rst(rst), .wr_hit(wr_hit),
    .wd_run(bus_wdata[B_RUN]), .wd_mask(bus_wdata[B_MASK]),
    .wd_flag(bus_wdata[B_FLAG]), .ev(ev),
    .run_q(run_q), .mask_q(mask_q), .flag_q(flag_q), .stat_q(stat_q)
  );

  acc_ctl_irq u_irq (
    .clk(clk), .rst(rst), .flag(flag_q), .mask(mask_q),
    .pp_irq(pp_irq), .irq_o(irq_o)
  );
endmodule

// File: rtl/acc_ctl_chk.sv
module acc_ctl_chk #(
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [4:0]        ev_vec,
  input logic              pp_irq,
  input logic              irq_o,
  input logic              run_q,
  input logic              flag_q,
  input logic [4:0]        stat_q
);
  logic hit;
  logic quiet;
  assign hit   = bus_wr && (bus_addr == ADDR_W'(REG_ADDR));
  assign quiet = (ev_vec == 5'd0);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!irq_o && !run_q && !flag_q && stat_q == 5'd0 && bus_rdata == 32'd0));

  // R3
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && bus_wdata[0] && quiet) |=> (run_q && stat_q == 5'd0));

  // R4
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    ev_vec[0] |=> (!run_q && stat_q[0] && flag_q));

  // R5
  busf_end_chk: assert property (@(posedge clk) disable iff (rst)
    ev_vec[1] |=> (!run_q && stat_q[1] && flag_q));

  // R5
  tmo_end_chk: assert property (@(posedge clk) disable iff (rst)
    ev_vec[4] |=> (!run_q && stat_q[4] && flag_q));

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !bus_wdata[0] && quiet) |=> $stable(stat_q));

  // R8
  pp_pass_chk: assert property (@(posedge clk) disable iff (rst)
    pp_irq |=> irq_o);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !bus_wdata[8] && quiet) |=> !flag_q);
endmodule

bind acc_ctl_reg acc_ctl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ev_vec({ev_timeout, ev_abort, ev_strm_err, ev_bus_err, ev_done}),
  .pp_irq(pp_irq), .irq_o(irq_o), .run_q(run_q), .flag_q(flag_q),
  .stat_q(stat_q)
);

// File: tb/test_acc_ctl_reg.sv
`timescale 1ns/1ps
module test_acc_ctl_reg;
  localparam int ADDR_W = 8;
  localparam int RA     = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic ev_done = 0, ev_strm_err = 0, ev_abort = 0, ev_bus_err = 0, ev_timeout = 0;
  logic pp_irq = 0;
  logic irq_o;
  int   total = 0, bad = 0;

  always #2.5 clk = ~clk;

  acc_ctl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(RA)) i_acc_ctl_reg (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_done(ev_done),
    .ev_strm_err(ev_strm_err), .ev_abort(ev_abort), .ev_bus_err(ev_bus_err),
    .ev_timeout(ev_timeout), .pp_irq(pp_irq), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_done = 1; 1: ev_strm_err = 1; 2: ev_abort = 1;
      3: ev_bus_err = 1; default: ev_timeout = 1;
    endcase
    @(negedge clk);
    {ev_done, ev_strm_err, ev_abort, ev_bus_err, ev_timeout} = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(RA, v);
    chk("R1 word after reset", v, 32'h0);
    chk("R1 irq after reset", {31'd0, irq_o}, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    wr(RA, 32'hFFFF_FFFF);
    rd(RA, v);
    chk("R2 writable bits only", v, 32'h0000_0111);
    chk("R6 status ignores write", v & 32'h0005_F000, 32'h0);
    wr(RA, 32'h0);
    rd(RA, v);
    chk("R2 cleared by write", v, 32'h0);
  endtask

  task automatic t_done();
    logic [31:0] v;
    wr(RA, 32'h1);
    rd(RA, v);
    chk("R3 run set", v, 32'h1);
    pulse(0);
    rd(RA, v);
    chk("R4 done ends run", v, 32'h0001_1100);
    chk("R11 pending bit", {31'd0, v[16]}, 32'h1);
    chk("R7 irq raised", {31'd0, irq_o}, 32'h1);
    wr(RA, 32'hFFFF_F000);
    rd(RA, v);
    chk("R9 flag cleared, R6 status kept", v, 32'h0000_1000);
    @(negedge clk);
    chk("R7 irq dropped", {31'd0, irq_o}, 32'h0);
    wr(RA, 32'h1);
    rd(RA, v);
    chk("R3 start clears status", v, 32'h1);
    wr(RA, 32'h0);
  endtask

  task automatic t_errors();
    logic [31:0] v;
    logic [31:0] bitv [5] = '{32'h1000, 32'h4000, 32'h8000, 32'h2000, 32'h4_0000};
    for (int i = 1; i < 5; i++) begin
      wr(RA, 32'h1);
      pulse(i);
      rd(RA, v);
      chk($sformatf("R5 event %0d", i), v, bitv[i] | 32'h0001_0100);
      wr(RA, 32'h0);
    end
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(RA, 32'h10);
    wr(RA, 32'h11);
    pulse(0);
    rd(RA, v);
    chk("R8 masked word", v, 32'h0000_1110);
    chk("R11 pending masked", {31'd0, v[16]}, 32'h0);
    chk("R8 irq held low", {31'd0, irq_o}, 32'h0);
    @(negedge clk); pp_irq = 1;
    @(negedge clk);
    chk("R8 pp flag passes", {31'd0, irq_o}, 32'h1);
    pp_irq = 0;
    @(negedge clk);
    chk("R7 irq follows pp low", {31'd0, irq_o}, 32'h0);
    wr(RA, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(RA, 32'h1);
    @(negedge clk);
    bus_wr = 1; bus_addr = RA; bus_wdata = 32'h1; ev_bus_err = 1;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0; ev_bus_err = 0;
    rd(RA, v);
    chk("R10 event beats write", v, 32'h0001_2100);
    wr(RA, 32'h0);
  endtask

  task automatic t_other();
    logic [31:0] v;
    wr(RA + 1, 32'h111);
    rd(RA, v);
    chk("R12 foreign write ignored", v, 32'h0000_2000);
    wr(RA, 32'h10);
    rd(RA + 1, v);
    chk("R12 foreign read zero", v, 32'h0);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_layout();
    t_done();
    t_errors();
    t_mask();
    t_collide();
    t_other();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule